// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Connect Controller

This controller decides when a plug-in card's two-wire serial bus (data and clock lines, I2C/SMBus style) may be joined to a backplane bus that is already carrying traffic. It samples the open-drain levels on both sides, two supply-good flags and an enable input. It keeps the sides apart until the backplane has finished a transaction and the card lines are released. After that it joins them.

Each line is modelled as open-drain. Every bus input is the level that the other devices on that side put on the wire, not counting this block's own pull. Once the sides are joined, a low from any device on one side makes the controller pull the same line low on the other side. The result is a wired-AND across both sides. The controller also gives enables for a rise-time accelerator and for a precharge circuit, and shows its state for debug.

Enabling is asymmetric. Turning the enable off disconnects at once. Turning it on takes effect only after a long, parameterised hold-off, and then the full qualification runs again.

Top module: `hsbus_connect_ctrl`

## Requirements
- R1: While either supply flag (`bp_pwr_ok`, `card_pwr_ok`) is low, the state is lockout and every bus input is ignored. The outputs `link_on`, `accel_en` and all four pull outputs stay 0.
- R2: `prechg_en` is 1 in the lockout, wait-idle and check-card states. It is 0 in the connected and disabled states.
- R3: In the wait-idle state, a backplane stop (backplane SDA rising while backplane SCL is high) qualifies a connection without any idle wait.
- R4: In the wait-idle state, `IDLE_CYCLES` consecutive cycles with both backplane lines high also qualify a connection. Any low on either line restarts the count, and the count starts afresh each time the wait-idle state is entered.
- R5: A qualifying event connects only if card SDA and card SCL are both high in that cycle. Otherwise the state becomes check-card. It stays there until both card lines are high, and then returns to wait-idle to look for a new event.
- R6: `link_on` and `accel_en` are both 1 exactly when the state is connected.
- R7: While connected, `bp_sda_pull` is 1 when the card SDA input is low, and `card_sda_pull` is 1 when the backplane SDA input is low. SCL works the same way. Every pull output is 0 while the block is not connected.
- R8: With both supplies good, a low enable forces the disabled state. This drops the connection, the accelerators and the precharge.
- R9: A high enable has effect only after it has been held high for `EN_DELAY_CYCLES` consecutive synchronised cycles. A shorter high pulse leaves the block disabled. When the enable does take effect, the state moves to wait-idle.
- R10: Loss of either supply while connected forces lockout, which drops the connection.
- R11: Every input passes through `SYNC_STAGES` flip-flops, so an input change appears in the state `SYNC_STAGES`+1 clock edges later. `dbg_state` encodes the states as lockout=0, wait-idle=1, check-card=2, connected=3, disabled=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset into lockout |
| bp_pwr_ok | input | 1 | Backplane supply good |
| card_pwr_ok | input | 1 | Card supply good |
| en_in | input | 1 | Connection enable |
| bp_sda_in | input | 1 | Backplane SDA level driven by other devices |
| bp_scl_in | input | 1 | Backplane SCL level driven by other devices |
| card_sda_in | input | 1 | Card SDA level driven by other devices |
| card_scl_in | input | 1 | Card SCL level driven by other devices |
| bp_sda_pull | output | 1 | Pull backplane SDA low |
| bp_scl_pull | output | 1 | Pull backplane SCL low |
| card_sda_pull | output | 1 | Pull card SDA low |
| card_scl_pull | output | 1 | Pull card SCL low |
| link_on | output | 1 | Sides joined |
| accel_en | output | 1 | Rise-time accelerator enable |
| prechg_en | output | 1 | Precharge enable |
| dbg_state | output | 3 | Current state code |

## Verification
The bench builds the block with `IDLE_CYCLES`=12, `EN_DELAY_CYCLES`=8 and `SYNC_STAGES`=2. These values make the idle window and the enable hold-off short enough to cross many times in one run. That lets the bench cover an idle-based connection, a stop-based connection that arrives well before the window ends, a window restarted by clock pulses, a card that is still busy when the event occurs, and enable pulses shorter than the hold-off. With two synchroniser stages, the exact latency of a supply loss can be tested one cycle before and at the cycle it is due.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;
   typedef enum logic [2:0] {
      ST_LOCKOUT    = 3'd0,
      ST_WAIT_IDLE  = 3'd1,
      ST_CHECK_CARD = 3'd2,
      ST_CONNECTED  = 3'd3,
      ST_DISABLED   = 3'd4
   } link_state_t;

   localparam int unsigned IN_BP_SDA   = 0;
   localparam int unsigned IN_BP_SCL   = 1;
   localparam int unsigned IN_CARD_SDA = 2;
   localparam int unsigned IN_CARD_SCL = 3;
   localparam int unsigned IN_EN       = 4;
   localparam int unsigned IN_BP_PWR   = 5;
   localparam int unsigned IN_CARD_PWR = 6;
   localparam int unsigned IN_COUNT    = 7;
endpackage

// File: rtl/hsbus_sync.sv
module hsbus_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsbus_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hsbus_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= '0;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hsbus_bus_watch.sv
module hsbus_bus_watch #(
   parameter int unsigned IDLE_CYCLES = 19000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic sda,
   input  logic scl,
   output logic stop_seen,
   output logic idle_seen
);
   localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_CYCLES);

   if (IDLE_CYCLES < 1) begin : g_bad_idle
      $error("hsbus_bus_watch: IDLE_CYCLES must be at least 1");
   end

   logic          sda_prev;
   logic [CW-1:0] quiet_cnt;
   logic          bus_high;

   assign bus_high = sda & scl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_prev <= 1'b0;
      else        sda_prev <= sda;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     quiet_cnt <= '0;
      else if (!arm || !bus_high)     quiet_cnt <= '0;
      else if (quiet_cnt != CNT_MAX)  quiet_cnt <= quiet_cnt + 1'b1;
   end

   assign stop_seen = scl & sda & ~sda_prev;
   assign idle_seen = (quiet_cnt == CNT_MAX);

   // idle window closes only after the lines were high and the watch was armed
   assert_idle_needs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      idle_seen |-> $past(bus_high && arm));

   // a stop always follows a cycle with data low
   assert_stop_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |-> $past(!sda));
endmodule

// File: rtl/hsbus_en_filter.sv
module hsbus_en_filter #(
   parameter int unsigned DELAY_CYCLES = 19000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_s,
   output logic en_ok
);
   localparam int unsigned CW = $clog2(DELAY_CYCLES + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(DELAY_CYCLES);

   if (DELAY_CYCLES < 1) begin : g_bad_delay
      $error("hsbus_en_filter: DELAY_CYCLES must be at least 1");
   end

   logic [CW-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    hold_cnt <= '0;
      else if (!en_s)                hold_cnt <= '0;
      else if (hold_cnt != CNT_MAX)  hold_cnt <= hold_cnt + 1'b1;
   end

   assign en_ok = (hold_cnt == CNT_MAX);

   // the hold-off is only satisfied by an enable that was high
   assert_en_ok_after_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      en_ok |-> $past(en_s));
endmodule

// File: rtl/hsbus_connect_ctrl.sv
module hsbus_connect_ctrl
   import hsbus_pkg::*;
#(
   parameter int unsigned IDLE_CYCLES     = 19000,
   parameter int unsigned EN_DELAY_CYCLES = 19000,
   parameter int unsigned SYNC_STAGES     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bp_pwr_ok,
   input  logic       card_pwr_ok,
   input  logic       en_in,
   input  logic       bp_sda_in,
   input  logic       bp_scl_in,
   input  logic       card_sda_in,
   input  logic       card_scl_in,
   output logic       bp_sda_pull,
   output logic       bp_scl_pull,
   output logic       card_sda_pull,
   output logic       card_scl_pull,
   output logic       link_on,
   output logic       accel_en,
   output logic       prechg_en,
   output logic [2:0] dbg_state
);
   localparam int unsigned NLINES = 2;

   logic [IN_COUNT-1:0] raw_in, syn_in;
   link_state_t state_q, state_d;
   logic pwr_good, card_hi, stop_seen, idle_seen, en_ok, qualify, watch_arm;

   assign raw_in[IN_BP_SDA]   = bp_sda_in;
   assign raw_in[IN_BP_SCL]   = bp_scl_in;
   assign raw_in[IN_CARD_SDA] = card_sda_in;
   assign raw_in[IN_CARD_SCL] = card_scl_in;
   assign raw_in[IN_EN]       = en_in;
   assign raw_in[IN_BP_PWR]   = bp_pwr_ok;
   assign raw_in[IN_CARD_PWR] = card_pwr_ok;

   hsbus_sync #(.WIDTH(IN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign watch_arm = (state_q == ST_WAIT_IDLE);

   hsbus_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
      .clk(clk), .rst_n(rst_n), .arm(watch_arm),
      .sda(syn_in[IN_BP_SDA]), .scl(syn_in[IN_BP_SCL]),
      .stop_seen(stop_seen), .idle_seen(idle_seen)
   );

   hsbus_en_filter #(.DELAY_CYCLES(EN_DELAY_CYCLES)) u_enf (
      .clk(clk), .rst_n(rst_n), .en_s(syn_in[IN_EN]), .en_ok(en_ok)
   );

   assign pwr_good = syn_in[IN_BP_PWR] & syn_in[IN_CARD_PWR];
   assign card_hi  = syn_in[IN_CARD_SDA] & syn_in[IN_CARD_SCL];
   assign qualify  = stop_seen | idle_seen;

   always_comb begin
      state_d = state_q;
      if (!pwr_good) begin
         state_d = ST_LOCKOUT;
      end else if (!syn_in[IN_EN]) begin
         state_d = ST_DISABLED;
      end else begin
         unique case (state_q)
            ST_LOCKOUT, ST_DISABLED: if (en_ok) state_d = ST_WAIT_IDLE;
                                     else       state_d = ST_DISABLED;
            ST_WAIT_IDLE:  if (qualify) state_d = card_hi ? ST_CONNECTED : ST_CHECK_CARD;
            ST_CHECK_CARD: if (card_hi) state_d = ST_WAIT_IDLE;
            ST_CONNECTED:  state_d = ST_CONNECTED;
            default:       state_d = ST_LOCKOUT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_LOCKOUT;
      else        state_q <= state_d;
   end

   assign link_on   = (state_q == ST_CONNECTED);
   assign accel_en  = (state_q == ST_CONNECTED);
   assign prechg_en = (state_q == ST_LOCKOUT) || (state_q == ST_WAIT_IDLE) ||
                      (state_q == ST_CHECK_CARD);
   assign dbg_state = state_q;

   // wired-AND across the two sides, one slice per line (0 = data, 1 = clock)
   logic [NLINES-1:0] bp_lvl, card_lvl, bp_pull, card_pull;
   assign bp_lvl   = {syn_in[IN_BP_SCL],   syn_in[IN_BP_SDA]};
   assign card_lvl = {syn_in[IN_CARD_SCL], syn_in[IN_CARD_SDA]};

   for (genvar l = 0; l < NLINES; l++) begin : g_line
      assign bp_pull[l]   = link_on & ~card_lvl[l];
      assign card_pull[l] = link_on & ~bp_lvl[l];
   end

   assign bp_sda_pull   = bp_pull[0];
   assign bp_scl_pull   = bp_pull[1];
   assign card_sda_pull = card_pull[0];
   assign card_scl_pull = card_pull[1];

   // supply loss reaches lockout on the next edge
   assert_pwr_loss_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (state_q == ST_LOCKOUT));

   // a low enable with good supplies never leaves the link up
   assert_en_low_disconnect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_good && !syn_in[IN_EN]) |=> (state_q == ST_DISABLED));

   // entering connected needs a qualifying event
   assert_connect_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_CONNECTED) |=> (state_q != ST_CONNECTED || $past(qualify)));

   // entering connected needs released card lines
   assert_connect_needs_card_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_CONNECTED) |=> (state_q != ST_CONNECTED || $past(card_hi)));

   // leaving disabled for wait-idle requires the enable hold-off
   assert_wake_needs_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DISABLED) |=> (state_q != ST_WAIT_IDLE || $past(en_ok)));
endmodule

// File: tb/tb_hsbus_connect_ctrl.sv
`timescale 1ns/1ps
module tb_hsbus_connect_ctrl;
   localparam int IDLE = 12;
   localparam int ENDL = 8;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bp_pwr_ok = 0, card_pwr_ok = 0, en_in = 1;
   logic bp_sda_in = 1, bp_scl_in = 1, card_sda_in = 1, card_scl_in = 1;
   logic bp_sda_pull, bp_scl_pull, card_sda_pull, card_scl_pull;
   logic link_on, accel_en, prechg_en;
   logic [2:0] dbg_state;

   always #2.5 clk = ~clk;

   hsbus_connect_ctrl #(.IDLE_CYCLES(IDLE), .EN_DELAY_CYCLES(ENDL), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .bp_pwr_ok(bp_pwr_ok), .card_pwr_ok(card_pwr_ok),
      .en_in(en_in), .bp_sda_in(bp_sda_in), .bp_scl_in(bp_scl_in),
      .card_sda_in(card_sda_in), .card_scl_in(card_scl_in),
      .bp_sda_pull(bp_sda_pull), .bp_scl_pull(bp_scl_pull),
      .card_sda_pull(card_sda_pull), .card_scl_pull(card_scl_pull),
      .link_on(link_on), .accel_en(accel_en), .prechg_en(prechg_en), .dbg_state(dbg_state)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   // behavioural reference: states 0 lockout,1 wait,2 check,3 connected,4 disabled
   int   m_state = 0, m_idle = 0, m_endly = 0;
   bit   m_sdad = 0;
   logic [6:0] m_s = '0;
   logic [6:0] m_hist[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_idle = 0; m_endly = 0; m_sdad = 0; m_s = '0;
         m_hist.delete();
      end else begin
         logic [6:0] cur;
         bit stop, ihit, eok, pwr, chi;
         int ns;
         cur  = {card_pwr_ok, bp_pwr_ok, en_in, card_scl_in, card_sda_in, bp_scl_in, bp_sda_in};
         stop = m_s[1] && m_s[0] && !m_sdad;
         ihit = (m_idle == IDLE);
         eok  = (m_endly == ENDL);
         pwr  = m_s[5] && m_s[6];
         chi  = m_s[2] && m_s[3];
         ns = m_state;
         if (!pwr) ns = 0;
         else if (!m_s[4]) ns = 4;
         else if (m_state == 0 || m_state == 4) ns = eok ? 1 : 4;
         else if (m_state == 1) begin
            if (stop || ihit) ns = chi ? 3 : 2;
         end else if (m_state == 2) begin
            if (chi) ns = 1;
         end
         if (m_state != 1 || !m_s[0] || !m_s[1]) m_idle = 0;
         else if (m_idle < IDLE) m_idle++;
         if (!m_s[4]) m_endly = 0;
         else if (m_endly < ENDL) m_endly++;
         m_sdad = m_s[0];
         m_hist.push_back(cur);
         if (m_hist.size() > SYNC) void'(m_hist.pop_front());
         m_s = (m_hist.size() == SYNC) ? m_hist[0] : '0;
         m_state = ns;
      end
   end

   task automatic cmp(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!finished) begin
         bit lk;
         lk = (m_state == 3);
         cmp("R11", "dbg_state", int'(dbg_state), m_state);
         cmp("R6", "link_on", int'(link_on), int'(lk));
         cmp("R6", "accel_en", int'(accel_en), int'(lk));
         cmp("R2", "prechg_en", int'(prechg_en), int'(m_state == 0 || m_state == 1 || m_state == 2));
         cmp("R7", "bp_sda_pull", int'(bp_sda_pull), int'(lk && !m_s[2]));
         cmp("R7", "bp_scl_pull", int'(bp_scl_pull), int'(lk && !m_s[3]));
         cmp("R7", "card_sda_pull", int'(card_sda_pull), int'(lk && !m_s[0]));
         cmp("R7", "card_scl_pull", int'(card_scl_pull), int'(lk && !m_s[1]));
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      cmp("R1", "reset state", int'(dbg_state), 0);
      rst_n = 1;
      // R1: only backplane supply, bus activity ignored
      bp_pwr_ok = 1;
      wait_cyc(3); bp_sda_in = 0; wait_cyc(2); bp_sda_in = 1; wait_cyc(5);
      cmp("R1", "lockout with one supply", int'(dbg_state), 0);
      cmp("R2", "precharge in lockout", int'(prechg_en), 1);
      // R4: idle-based connection
      card_pwr_ok = 1;
      wait_cyc(30);
      cmp("R4", "idle connect state", int'(dbg_state), 3);
      cmp("R6", "accel after connect", int'(accel_en), 1);
      cmp("R2", "precharge off connected", int'(prechg_en), 0);
      // R7: wired-AND both directions
      card_sda_in = 0; wait_cyc(4);
      cmp("R7", "card sda low pulls bp", int'(bp_sda_pull), 1);
      cmp("R7", "card side not self-pulled", int'(card_sda_pull), 0);
      card_sda_in = 1; bp_scl_in = 0; wait_cyc(4);
      cmp("R7", "bp scl low pulls card", int'(card_scl_pull), 1);
      bp_scl_in = 1; wait_cyc(4);
      // R8: enable off at once
      en_in = 0; wait_cyc(4);
      cmp("R8", "disabled state", int'(dbg_state), 4);
      cmp("R8", "precharge off disabled", int'(prechg_en), 0);
      // R9: short pulse ignored, long high honoured
      en_in = 1; wait_cyc(4); en_in = 0; wait_cyc(2);
      cmp("R9", "short enable pulse", int'(dbg_state), 4);
      en_in = 1; wait_cyc(5);
      cmp("R9", "still within hold-off", int'(dbg_state), 4);
      wait_cyc(9);
      cmp("R9", "hold-off elapsed", int'(dbg_state), 1);
      // R3: stop connects before idle window
      bp_sda_in = 0; wait_cyc(2); bp_sda_in = 1; wait_cyc(5);
      cmp("R3", "stop connect", int'(dbg_state), 3);
      // R5: card busy at event
      en_in = 0; wait_cyc(4); card_sda_in = 0; en_in = 1; wait_cyc(34);
      cmp("R5", "card busy check state", int'(dbg_state), 2);
      cmp("R2", "precharge in check", int'(prechg_en), 1);
      card_sda_in = 1; wait_cyc(4);
      cmp("R5", "back to wait", int'(dbg_state), 1);
      wait_cyc(20);
      cmp("R5", "connect after release", int'(dbg_state), 3);
      // R4: idle restart by clock pulses
      en_in = 0; wait_cyc(4); en_in = 1; wait_cyc(14);
      for (int i = 0; i < 3; i++) begin
         bp_scl_in = 0; wait_cyc(1); bp_scl_in = 1; wait_cyc(8);
      end
      cmp("R4", "idle restarted", int'(dbg_state), 1);
      wait_cyc(20);
      cmp("R4", "idle after restart", int'(dbg_state), 3);
      // R10/R11: card supply loss and its latency
      card_pwr_ok = 0; wait_cyc(SYNC);
      cmp("R11", "sync latency not yet", int'(link_on), 1);
      wait_cyc(1);
      cmp("R10", "lockout after card loss", int'(dbg_state), 0);
      cmp("R10", "link dropped", int'(link_on), 0);
      card_pwr_ok = 1; wait_cyc(30);
      cmp("R1", "reconnect after restore", int'(dbg_state), 3);
      wait_cyc(2);
      finish_run();
   end
endmodule